// File: doc/BRIEF.md
# Delayed Read Completion Master

This block is the target-bus master sequencer of a bus bridge. It replays a read request that another part of the bridge has already captured from an initiator and has put in a delayed transaction queue. The sequencer waits until that request is at the head of the queue and no posted write is still outstanding. It then requests the target bus, waits for the grant and runs a simplified parallel-bus read. The address phase carries the captured address and command without any change. Every data word the target accepts goes out through a completion buffer write port.

When the target asks for a retry before any data has moved, the sequencer gives up the bus, counts the attempt and runs the same read again. Once at least one word has arrived, a normal end or a disconnect from the target closes the request for good. A missing device select or a target abort also ends the request, with a status code. A prefetchable read bursts with all byte lanes enabled until the completion buffer reports almost-full. A nonprefetchable read moves a single word with the captured byte enables.

The captured address, command, byte enables and prefetch flag must stay valid for as long as `req_valid` is high. Status (done or error) is held until `req_valid` is dropped.

Top module: `drc_master`

## Requirements
- R1: A read starts only after a clock edge that samples `req_valid` high, `at_head` high and `posted_pending` low. The first visible sign of the start is `bus_req_n` going low in the following cycle. The same condition must hold again before a retried attempt requests the bus.
- R2: While `bus_req_n` is low, the first clock edge that samples `bus_gnt_n` low starts the address phase in the next cycle. No address phase starts without a grant.
- R3: The address phase lasts one cycle. In it, `frame_n` is 0, `irdy_n` is 1, `ad_oe` is 1, `ad_out` equals `cap_addr` and `cbe_n` equals `cap_cmd`. Every retried attempt uses these same values.
- R4: For a nonprefetchable read (`cap_prefetch` = 0), the cycle after the address phase has `irdy_n` = 0, `frame_n` = 1 and `cbe_n` = `cap_be_n`. At most one word is transferred.
- R5: For a prefetchable read (`cap_prefetch` = 1), `cbe_n` is 4'b0000 in every data phase.
- R6: In any data-phase cycle where `trdy_n` and `devsel_n` are both 0, `cbuf_we` is 1 and `cbuf_wdata` equals `ad_in` in that same cycle. In no other cycle is `cbuf_we` 1.
- R7: A retry is a data-phase edge that samples `stop_n` = 0, `devsel_n` = 0 and `trdy_n` = 1 before any word has been transferred. On a retry, the bus is released, `retry_count` increments and the read is requested again.
- R8: Once a word has been transferred, the read completes at either of two points: the transfer on a phase where `frame_n` is 1, or a `stop_n` = 0 sample with `devsel_n` = 0 (with or without data). On completion, `done` goes to 1 and no further request or address phase follows. `done` holds until `req_valid` is dropped.
- R9: If `devsel_n` is still 1 on the fifth data-phase cycle after the address phase, `err` goes to 1 with `err_code` = 2'b01 (master abort).
- R10: A data-phase edge that samples `stop_n` = 0 with `devsel_n` = 1 sets `err` to 1 with `err_code` = 2'b10 (target abort). No retry follows.
- R11: In a prefetchable read, `frame_n` goes to 1 in the cycle after a clock edge of the address phase or a data phase samples `cbuf_afull` high. The next transfer then ends the read. With almost-full first reported after word k (counting from 0), k+2 words are transferred; with almost-full already high at the address phase, 1 word is transferred.
- R12: `retry_count` is 16 bits wide and cleared when a new request starts from idle. It saturates at all ones and holds its value after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A captured delayed read is present |
| at_head | input | 1 | The request is at the head of the delayed transaction queue |
| posted_pending | input | 1 | An earlier posted write has not yet been delivered |
| cap_addr | input | 32 | Captured read address |
| cap_cmd | input | 4 | Captured read command |
| cap_be_n | input | 4 | Captured byte enables, active low |
| cap_prefetch | input | 1 | Captured read is prefetchable |
| bus_req_n | output | 1 | Bus request, active low |
| bus_gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | Cycle frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| cbe_n | output | 4 | Command / byte enables, active low |
| ad_out | output | 32 | Address driven in the address phase |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ad_in | input | 32 | Read data from the target |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop, active low |
| devsel_n | input | 1 | Device select, active low |
| cbuf_we | output | 1 | Completion buffer write strobe |
| cbuf_wdata | output | 32 | Completion buffer write data |
| cbuf_afull | input | 1 | Completion buffer almost full |
| done | output | 1 | Request completed with data |
| err | output | 1 | Request ended with an error |
| err_code | output | 2 | 01 master abort, 10 target abort |
| retry_count | output | 16 | Number of retried attempts |

## Verification
On every cycle, the assertions check several rules: a request only follows the queue-head and no-pending-write condition, an address phase only follows a grant, the address phase carries the captured address and command, and prefetchable data phases enable all lanes. They also check that a nonprefetchable read never writes two words in a row, that the bus stays quiet once done, that an error always carries a code, and that the retry counter stays at all ones once there. Only the bench scenarios can show the counts and orderings across a whole transaction. These include the number of retries before completion, the exact word count set by almost-full, and the data values written. They also include the wait for a delayed grant, the five-cycle master abort window, the end of a disconnect without further attempts, and the clearing of status when the request is withdrawn.

// File: rtl/drc_pkg.sv
package drc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_BACKOFF,
        ST_DONE,
        ST_FAIL
    } drc_st_e;

    localparam logic [1:0] ERR_NONE   = 2'b00;
    localparam logic [1:0] ERR_MASTER = 2'b01;
    localparam logic [1:0] ERR_TARGET = 2'b10;

endpackage

// File: rtl/drc_sat_counter.sv
module drc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.cnt = '0;
        end else if (inc && (q.cnt != MAX)) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.cnt;

    // R12
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == MAX && !clr) |=> (count == MAX));

endmodule

// File: rtl/drc_devsel_timer.sv
module drc_devsel_timer #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  logic devsel_n,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          seen;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.cnt  = '0;
            d.seen = 1'b0;
        end else if (run) begin
            if (!devsel_n) d.seen = 1'b1;
            if (q.cnt != LAST) d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expire = run && devsel_n && !q.seen && (q.cnt == LAST);

endmodule

// File: rtl/drc_seq.sv
module drc_seq
    import drc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       at_head,
    input  logic       posted_pending,
    input  logic       cap_prefetch,
    input  logic       cbuf_afull,
    input  logic       bus_gnt_n,
    input  logic       trdy_n,
    input  logic       stop_n,
    input  logic       devsel_n,
    input  logic       abort_expire,
    output drc_st_e    st,
    output logic       last,
    output logic       cnt_clr,
    output logic       cnt_inc,
    output logic       xfer,
    output logic [1:0] err_code
);

    typedef struct packed {
        drc_st_e    st;
        logic       got;
        logic       last;
        logic [1:0] code;
    } seq_t;

    seq_t q, d;

    logic gate_ok;
    logic in_data;
    logic tgt_abort;
    logic tgt_stop;

    assign gate_ok   = req_valid && at_head && !posted_pending;
    assign in_data   = (q.st == ST_DATA);
    assign tgt_abort = in_data && !stop_n && devsel_n;
    assign tgt_stop  = !stop_n && !devsel_n;
    assign xfer      = in_data && !trdy_n && !devsel_n;

    always_comb begin
        d       = q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (gate_ok) begin
                    d.st    = ST_REQ;
                    d.got   = 1'b0;
                    d.code  = ERR_NONE;
                    cnt_clr = 1'b1;
                end
            end
            ST_REQ: begin
                if (!req_valid) begin
                    d.st = ST_IDLE;
                end else if (!bus_gnt_n) begin
                    d.st   = ST_ADDR;
                    d.last = !cap_prefetch;
                end
            end
            ST_ADDR: begin
                d.st   = ST_DATA;
                d.last = q.last || cbuf_afull;
            end
            ST_DATA: begin
                d.last = q.last || cbuf_afull;
                if (tgt_abort) begin
                    d.st   = ST_FAIL;
                    d.code = ERR_TARGET;
                end else if (abort_expire) begin
                    d.st   = ST_FAIL;
                    d.code = ERR_MASTER;
                end else if (xfer) begin
                    d.got = 1'b1;
                    if (tgt_stop || q.last) d.st = ST_DONE;
                end else if (tgt_stop) begin
                    if (q.got) begin
                        d.st = ST_DONE;
                    end else begin
                        d.st    = ST_BACKOFF;
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_BACKOFF: begin
                if (!req_valid)  d.st = ST_IDLE;
                else if (gate_ok) d.st = ST_REQ;
            end
            ST_DONE, ST_FAIL: begin
                if (!req_valid) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.got  <= 1'b0;
            q.last <= 1'b0;
            q.code <= ERR_NONE;
        end else begin
            q <= d;
        end
    end

    assign st       = q.st;
    assign last     = q.last;
    assign err_code = q.code;

    // R10
    fail_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FAIL) |-> (q.code != ERR_NONE));

    // R7
    retry_only_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_inc |-> !q.got);

endmodule

// File: rtl/drc_bus_drive.sv
module drc_bus_drive
    import drc_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = AD_W / 8
) (
    input  drc_st_e         st,
    input  logic            last,
    input  logic [AD_W-1:0] cap_addr,
    input  logic [3:0]      cap_cmd,
    input  logic [BE_W-1:0] cap_be_n,
    input  logic            cap_prefetch,
    output logic            bus_req_n,
    output logic            frame_n,
    output logic            irdy_n,
    output logic            ad_oe,
    output logic [AD_W-1:0] ad_out,
    output logic [BE_W-1:0] cbe_n,
    output logic            done,
    output logic            err
);
    localparam int CMD_PAD = BE_W - 4;

    logic in_addr;
    logic in_data;

    assign in_addr = (st == ST_ADDR);
    assign in_data = (st == ST_DATA);

    always_comb begin
        bus_req_n = !(st == ST_REQ);
        frame_n   = !(in_addr || (in_data && !last));
        irdy_n    = !in_data;
        ad_oe     = in_addr;
        ad_out    = in_addr ? cap_addr : '0;
        done      = (st == ST_DONE);
        err       = (st == ST_FAIL);
        if (in_addr) begin
            cbe_n = {{CMD_PAD{1'b1}}, cap_cmd};
        end else if (in_data) begin
            cbe_n = cap_prefetch ? '0 : cap_be_n;
        end else begin
            cbe_n = '1;
        end
    end

endmodule

// File: rtl/drc_master.sv
module drc_master
    import drc_pkg::*;
#(
    parameter int AD_W       = 32,
    parameter int CNT_W      = 16,
    parameter int ABORT_CLKS = 5,
    localparam int BE_W      = AD_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             at_head,
    input  logic             posted_pending,
    input  logic [AD_W-1:0]  cap_addr,
    input  logic [3:0]       cap_cmd,
    input  logic [BE_W-1:0]  cap_be_n,
    input  logic             cap_prefetch,
    output logic             bus_req_n,
    input  logic             bus_gnt_n,
    output logic             frame_n,
    output logic             irdy_n,
    output logic [BE_W-1:0]  cbe_n,
    output logic [AD_W-1:0]  ad_out,
    output logic             ad_oe,
    input  logic [AD_W-1:0]  ad_in,
    input  logic             trdy_n,
    input  logic             stop_n,
    input  logic             devsel_n,
    output logic             cbuf_we,
    output logic [AD_W-1:0]  cbuf_wdata,
    input  logic             cbuf_afull,
    output logic             done,
    output logic             err,
    output logic [1:0]       err_code,
    output logic [CNT_W-1:0] retry_count
);

    drc_st_e st;
    logic    last;
    logic    cnt_clr;
    logic    cnt_inc;
    logic    xfer;
    logic    expire;

    drc_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .at_head       (at_head),
        .posted_pending(posted_pending),
        .cap_prefetch  (cap_prefetch),
        .cbuf_afull    (cbuf_afull),
        .bus_gnt_n     (bus_gnt_n),
        .trdy_n        (trdy_n),
        .stop_n        (stop_n),
        .devsel_n      (devsel_n),
        .abort_expire  (expire),
        .st            (st),
        .last          (last),
        .cnt_clr       (cnt_clr),
        .cnt_inc       (cnt_inc),
        .xfer          (xfer),
        .err_code      (err_code)
    );

    drc_devsel_timer #(.LIMIT(ABORT_CLKS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (st == ST_ADDR),
        .run     (st == ST_DATA),
        .devsel_n(devsel_n),
        .expire  (expire)
    );

    drc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .count(retry_count)
    );

    drc_bus_drive #(.AD_W(AD_W), .BE_W(BE_W)) u_drv (
        .st          (st),
        .last        (last),
        .cap_addr    (cap_addr),
        .cap_cmd     (cap_cmd),
        .cap_be_n    (cap_be_n),
        .cap_prefetch(cap_prefetch),
        .bus_req_n   (bus_req_n),
        .frame_n     (frame_n),
        .irdy_n      (irdy_n),
        .ad_oe       (ad_oe),
        .ad_out      (ad_out),
        .cbe_n       (cbe_n),
        .done        (done),
        .err         (err)
    );

    assign cbuf_we    = xfer;
    assign cbuf_wdata = ad_in;

    // R1
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req_n) |-> $past(req_valid && at_head && !posted_pending));

    // R2
    addr_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> $past(!bus_gnt_n && !bus_req_n));

    // R3
    addr_phase_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !frame_n) |-> (ad_out == cap_addr && cbe_n[3:0] == cap_cmd && irdy_n));

    // R5
    prefetch_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && cap_prefetch) |-> (cbe_n == '0));

    // R4
    single_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cbuf_we && !cap_prefetch) |=> !cbuf_we);

    // R6
    we_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cbuf_we |-> (!irdy_n && !trdy_n && !devsel_n));

    // R8
    quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_req_n && frame_n && irdy_n && !cbuf_we));

endmodule

// File: tb/sim_drc_master.sv
module sim_drc_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        at_head = 1'b0;
    logic        posted_pending = 1'b0;
    logic [31:0] cap_addr = '0;
    logic [3:0]  cap_cmd = '0;
    logic [3:0]  cap_be_n = '1;
    logic        cap_prefetch = 1'b0;
    logic        bus_req_n;
    logic        bus_gnt_n = 1'b1;
    logic        frame_n;
    logic        irdy_n;
    logic [3:0]  cbe_n;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic [31:0] ad_in = '0;
    logic        trdy_n = 1'b1;
    logic        stop_n = 1'b1;
    logic        devsel_n = 1'b1;
    logic        cbuf_we;
    logic [31:0] cbuf_wdata;
    logic        cbuf_afull = 1'b0;
    logic        done;
    logic        err;
    logic [1:0]  err_code;
    logic [15:0] retry_count;

    always #2 clk = ~clk;

    drc_master u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .at_head(at_head),
        .posted_pending(posted_pending), .cap_addr(cap_addr), .cap_cmd(cap_cmd),
        .cap_be_n(cap_be_n), .cap_prefetch(cap_prefetch), .bus_req_n(bus_req_n),
        .bus_gnt_n(bus_gnt_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .trdy_n(trdy_n),
        .stop_n(stop_n), .devsel_n(devsel_n), .cbuf_we(cbuf_we),
        .cbuf_wdata(cbuf_wdata), .cbuf_afull(cbuf_afull), .done(done), .err(err),
        .err_code(err_code), .retry_count(retry_count)
    );

    typedef struct packed {
        logic        pf;
        logic [3:0]  be;
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [7:0]  nretry;
        logic [7:0]  afull;
        logic [3:0]  gd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'b1010, 4'h6, 32'h1000_0040, 8'd0, 8'd0, 4'd0},
        '{1'b0, 4'b0011, 4'h6, 32'h2000_0104, 8'd3, 8'd0, 4'd2},
        '{1'b1, 4'b1111, 4'hC, 32'h3000_0200, 8'd0, 8'd3, 4'd0},
        '{1'b1, 4'b0101, 4'hE, 32'h4000_0800, 8'd2, 8'd0, 4'd1},
        '{1'b1, 4'b0000, 4'hC, 32'h5000_0000, 8'd1, 8'd5, 4'd3},
        '{1'b0, 4'b1110, 4'h6, 32'h6000_000C, 8'd7, 8'd0, 4'd0}
    };

    int n_chk = 0;
    int n_bad = 0;
    int r_words, r_dph, r_att;
    bit fin = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode: 0 normal, 1 disconnect with data at word disc, 2 stop without data
    // once disc words moved, 3 no device select, 4 target abort
    task automatic run_txn(input bit pf, input logic [3:0] be, input logic [3:0] cmd,
                           input logic [31:0] addr, input int nretry, input int afull_after,
                           input int mode, input int disc, input int gd);
        int cyc = 0, gcount = 0, reqc = 0;
        bit exp_we;
        cap_prefetch = pf; cap_be_n = be; cap_cmd = cmd; cap_addr = addr;
        cbuf_afull = pf && (afull_after == 0);
        req_valid = 1'b1; at_head = 1'b1; posted_pending = 1'b0;
        r_words = 0; r_dph = 0; r_att = 0;
        while (cyc < 500) begin
            @(negedge clk);
            cyc++;
            if (done || err) break;
            trdy_n = 1'b1; stop_n = 1'b1; devsel_n = 1'b1; ad_in = '0; exp_we = 1'b0;
            if (!bus_req_n) begin
                reqc++;
                if (gcount >= gd) bus_gnt_n = 1'b0;
                else begin bus_gnt_n = 1'b1; gcount++; end
            end else begin
                bus_gnt_n = 1'b1; gcount = 0;
            end
            if (ad_oe) begin
                r_att++;
                r_dph = 0;
                check(!frame_n && irdy_n, "R3 frame/irdy in address phase", {30'd0, frame_n, irdy_n}, 32'd1);
                check(ad_out == addr, "R3 address", ad_out, addr);
                check(cbe_n == cmd, "R3 command", {28'd0, cbe_n}, {28'd0, cmd});
                check(reqc == gd + 1, "R2 request cycles before address", reqc, gd + 1);
                reqc = 0;
            end
            if (!irdy_n) begin
                r_dph++;
                if (pf) check(cbe_n == 4'h0, "R5 prefetch lanes", {28'd0, cbe_n}, 32'd0);
                else begin
                    check(cbe_n == be, "R4 captured enables", {28'd0, cbe_n}, {28'd0, be});
                    check(frame_n, "R4 single phase frame", {31'd0, frame_n}, 32'd1);
                end
                if (r_att <= nretry) begin
                    devsel_n = 1'b0; stop_n = 1'b0;
                end else begin
                    case (mode)
                        0: begin devsel_n = 1'b0; trdy_n = 1'b0; exp_we = 1'b1; end
                        1: begin devsel_n = 1'b0; trdy_n = 1'b0; exp_we = 1'b1;
                                 if (r_words == disc) stop_n = 1'b0; end
                        2: begin devsel_n = 1'b0;
                                 if (r_words < disc) begin trdy_n = 1'b0; exp_we = 1'b1; end
                                 else stop_n = 1'b0; end
                        4: begin stop_n = 1'b0; end
                        default: ;
                    endcase
                end
                if (exp_we) ad_in = addr + 32'(r_words * 4);
                #1;
                check(cbuf_we == exp_we, "R6 write strobe", {31'd0, cbuf_we}, {31'd0, exp_we});
                if (exp_we) begin
                    check(cbuf_wdata == ad_in, "R6 write data", cbuf_wdata, ad_in);
                    r_words++;
                end
                cbuf_afull = pf && (r_words >= afull_after);
            end
        end
        trdy_n = 1'b1; stop_n = 1'b1; devsel_n = 1'b1; bus_gnt_n = 1'b1; cbuf_afull = 1'b0;
    endtask

    task automatic release_req(input string req);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(bus_req_n && frame_n && irdy_n, {req, " bus quiet after end"},
                  {29'd0, bus_req_n, frame_n, irdy_n}, 32'd7);
        end
        req_valid = 1'b0; at_head = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!done && !err, {req, " status cleared"}, {30'd0, done, err}, 32'd0);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bus_req_n && frame_n && irdy_n && !ad_oe, "R1 reset bus idle",
              {28'd0, bus_req_n, frame_n, irdy_n, ad_oe}, 32'hE);
        check(!done && !err && retry_count == 0, "R12 reset status",
              {14'd0, done, err, retry_count}, 32'd0);
        rst_n = 1'b1;

        // R1: held off by a pending posted write, then by not being at the head
        req_valid = 1'b1; at_head = 1'b1; posted_pending = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(bus_req_n, "R1 held by posted write", {31'd0, bus_req_n}, 32'd1);
        end
        posted_pending = 1'b0; at_head = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(bus_req_n, "R1 held off head", {31'd0, bus_req_n}, 32'd1);
        end
        at_head = 1'b1;
        @(negedge clk);
        check(!bus_req_n, "R1 request after gate opens", {31'd0, bus_req_n}, 32'd0);
        req_valid = 1'b0; at_head = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(bus_req_n, "R1 request withdrawn", {31'd0, bus_req_n}, 32'd1);

        // table of normal completions
        for (int v = 0; v < NV; v++) begin
            int exp_words;
            exp_words = VECS[v].pf ? int'(VECS[v].afull) + 1 : 1;
            if (VECS[v].pf && VECS[v].afull == 0) exp_words = 1;
            run_txn(VECS[v].pf, VECS[v].be, VECS[v].cmd, VECS[v].addr,
                    int'(VECS[v].nretry), int'(VECS[v].afull), 0, 0, int'(VECS[v].gd));
            check(done && !err, "R8 done", {30'd0, done, err}, 32'd2);
            check(r_words == exp_words, "R11 word count", r_words, exp_words);
            check(r_att == int'(VECS[v].nretry) + 1, "R7 attempts", r_att, int'(VECS[v].nretry) + 1);
            check(retry_count == 16'(VECS[v].nretry), "R12 retry count",
                  {16'd0, retry_count}, {24'd0, VECS[v].nretry});
            release_req("R8");
        end

        // R8: disconnect with data on the second word, no further attempt
        run_txn(1'b1, 4'h0, 4'hC, 32'h7000_0000, 0, 100, 1, 1, 0);
        check(done && r_words == 2 && r_att == 1, "R8 disconnect with data",
              {r_words[15:0], 15'd0, done}, {16'd2, 16'd1});
        release_req("R8");

        // R8: stop without data after two words, one retry before that
        run_txn(1'b1, 4'h0, 4'hC, 32'h7100_0000, 1, 100, 2, 2, 1);
        check(done && r_words == 2 && r_att == 2, "R8 disconnect after data",
              {r_words[15:0], 15'd0, done}, {16'd2, 16'd1});
        check(retry_count == 16'd1, "R12 count held after disconnect", {16'd0, retry_count}, 32'd1);
        release_req("R8");

        // R9: master abort after five data cycles without device select
        run_txn(1'b0, 4'h3, 4'h6, 32'h7200_0010, 0, 0, 3, 0, 0);
        check(err && err_code == 2'b01, "R9 master abort code", {30'd0, err_code}, 32'd1);
        check(r_dph == 5, "R9 abort window", r_dph, 5);
        check(r_att == 1, "R9 no retry after abort", r_att, 1);
        release_req("R9");

        // R10: target abort on first data phase
        run_txn(1'b1, 4'h0, 4'hE, 32'h7300_0020, 0, 100, 4, 0, 0);
        check(err && err_code == 2'b10, "R10 target abort code", {30'd0, err_code}, 32'd2);
        check(r_dph == 1 && r_att == 1, "R10 single attempt", {r_dph[15:0], r_att[15:0]}, {16'd1, 16'd1});
        release_req("R10");

        // R12: count cleared by a fresh request
        run_txn(1'b0, 4'h0, 4'h6, 32'h7400_0000, 0, 0, 0, 0, 0);
        check(retry_count == 16'd0, "R12 cleared on new request", {16'd0, retry_count}, 32'd0);
        release_req("R12");

        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule